// File: doc/BRIEF.md
# Accumulator Arithmetic Unit with Flags

This unit does the byte arithmetic for an accumulator-style microcontroller datapath. A decoded operation select chooses one of the following:

- add, add with carry, or subtract with borrow, each combining the accumulator byte with a second operand byte;
- increment or decrement of a single byte;
- BCD decimal adjust of the accumulator;
- increment of a 16-bit data pointer.

For the byte operations, the result and the next values of the carry (CY), auxiliary-carry (AC) and overflow (OV) flags appear combinationally in the same cycle. Each flag has its own write-enable, so the flag register outside the block is written only where the operation defines it.

The pointer increment takes two cycles. In the issue cycle the low byte is incremented and registered. In the following cycle the high byte absorbs the carry, and the new 16-bit value is presented with a one-cycle write strobe. A busy output covers that second cycle, and pointer issues made while it is high are dropped. Operand addressing, fetch, multiply and divide are handled elsewhere.

Top module: `accAlu`

## Requirements
- R1: Operation select encoding is 0 add, 1 add-with-carry, 2 subtract-with-borrow, 3 increment, 4 decrement, 5 decimal adjust, 6 pointer increment, 7 no operation. With `opValid` high, codes 0, 1 and 2 assert all three flag write-enables (CY, AC, OV).
- R2: Add gives `accIn + operandIn` modulo 256 and ignores `cyIn`. CY is the carry out of bit 7, AC is the carry out of bit 3, and OV is the carry into bit 7 XOR the carry out of bit 7.
- R3: Add-with-carry gives `accIn + operandIn + cyIn`, with CY, AC and OV defined as in R2.
- R4: Subtract-with-borrow gives `accIn - operandIn - cyIn` modulo 256. CY is set on a borrow out of bit 7. AC is set on a borrow into bit 4. OV is set when the operands have different signs and the result's sign differs from `accIn`.
- R5: Increment and decrement act on `operandIn` and wrap modulo 256 (0xFF+1 gives 0x00, and 0x00-1 gives 0xFF). They assert no flag write-enable.
- R6: Decimal adjust first adds 0x06 to `accIn` when its low nibble exceeds 9 or `acIn` is set. It then adds 0x60 when the resulting high nibble exceeds 9, `cyIn` is set, or the first step carried.
- R7: During decimal adjust only the CY write-enable is asserted. `cyOut` is set if either step carried and otherwise equals `cyIn`, so it never clears a set carry.
- R8: A pointer increment issued with `busy` low produces `ptrOut = ptrIn + 1` (0xFFFF wraps to 0x0000) with `ptrWe` high for exactly the one cycle after the issue cycle. `busy` is high in that cycle, and a pointer issue made then is ignored. The pointer increment writes no flag.
- R9: With `opValid` low, or with code 7, no flag write-enable is asserted.
- R10: After reset `busy` and `ptrWe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| opValid | input | 1 | Operation select is valid this cycle |
| opSel | input | 3 | Operation code (R1) |
| accIn | input | 8 | Accumulator operand |
| operandIn | input | 8 | Second operand, or byte to increment/decrement |
| cyIn | input | 1 | Current carry flag |
| acIn | input | 1 | Current auxiliary-carry flag |
| ptrIn | input | 16 | Data pointer value |
| result | output | 8 | Byte result |
| cyOut | output | 1 | Next carry flag |
| acOut | output | 1 | Next auxiliary-carry flag |
| ovOut | output | 1 | Next overflow flag |
| cyWe | output | 1 | Carry flag write-enable |
| acWe | output | 1 | Auxiliary-carry write-enable |
| ovWe | output | 1 | Overflow write-enable |
| ptrOut | output | 16 | Incremented pointer |
| ptrWe | output | 1 | Pointer write strobe |
| busy | output | 1 | Pointer increment in its second cycle |

## Verification
A wrong nibble carry or a wrong sign decision in the shared adder shows up on `acOut` or `ovOut` in the same cycle as the operands. The operand vectors are chosen so that each flag toggles on its own. A wrong decode into the control strobes shows at once on a write-enable that should be off, for example AC during decimal adjust or any flag during increment. The pointer path holds the only state. A dropped low-byte carry or a mistimed phase register shows one cycle after issue, as a wrong `ptrOut` high byte or a `ptrWe` strobe that is missing or repeated.

// File: rtl/accAluPkg.sv
package accAluPkg;
  localparam int DATA_W = 8;
  localparam int PTR_W  = 16;
  localparam int NIB_W  = DATA_W / 2;

  typedef enum logic [2:0] {
    OP_ADD    = 3'd0,
    OP_ADDC   = 3'd1,
    OP_SUBB   = 3'd2,
    OP_INC    = 3'd3,
    OP_DEC    = 3'd4,
    OP_DADJ   = 3'd5,
    OP_PTRINC = 3'd6,
    OP_NONE   = 3'd7
  } opKindT;

  typedef enum logic [1:0] {
    RES_ADDER = 2'd0,
    RES_INC   = 2'd1,
    RES_DEC   = 2'd2,
    RES_DADJ  = 2'd3
  } resSelT;

  typedef struct packed {
    logic   subMode;
    logic   useCarry;
    resSelT resSel;
    logic   cyWe;
    logic   acWe;
    logic   ovWe;
    logic   ptrCapture;
    logic   ptrDrive;
  } strobeT;
endpackage

// File: rtl/accAluCtrl.sv
module accAluCtrl
  import accAluPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic [2:0] opSel,
  output strobeT     strobes,
  output logic       busy
);
  logic ptrPhase;
  logic ptrAccept;

  assign ptrAccept = opValid && (opSel == OP_PTRINC) && !ptrPhase;
  assign busy      = ptrPhase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ptrPhase <= 1'b0;
    else       ptrPhase <= ptrAccept;
  end

  always_comb begin
    strobes            = '0;
    strobes.resSel     = RES_ADDER;
    strobes.ptrCapture = ptrAccept;
    strobes.ptrDrive   = ptrPhase;
    if (opValid) begin
      unique case (opSel)
        OP_ADD: begin
          strobes.cyWe = 1'b1; strobes.acWe = 1'b1; strobes.ovWe = 1'b1;
        end
        OP_ADDC: begin
          strobes.useCarry = 1'b1;
          strobes.cyWe = 1'b1; strobes.acWe = 1'b1; strobes.ovWe = 1'b1;
        end
        OP_SUBB: begin
          strobes.subMode  = 1'b1;
          strobes.useCarry = 1'b1;
          strobes.cyWe = 1'b1; strobes.acWe = 1'b1; strobes.ovWe = 1'b1;
        end
        OP_INC:  strobes.resSel = RES_INC;
        OP_DEC:  strobes.resSel = RES_DEC;
        OP_DADJ: begin
          strobes.resSel = RES_DADJ;
          strobes.cyWe   = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/accAluData.sv
module accAluData
  import accAluPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobeT             strobes,
  input  logic [DATA_W-1:0]  accIn,
  input  logic [DATA_W-1:0]  operandIn,
  input  logic               cyIn,
  input  logic               acIn,
  input  logic [PTR_W-1:0]   ptrIn,
  output logic [DATA_W-1:0]  result,
  output logic               cyOut,
  output logic               acOut,
  output logic               ovOut,
  output logic [PTR_W-1:0]   ptrOut
);
  localparam int HALF_PTR = PTR_W / 2;
  localparam logic [DATA_W:0] LOW_FIX  = (DATA_W+1)'(6);
  localparam logic [DATA_W:0] HIGH_FIX = (DATA_W+1)'(6) << NIB_W;

  // Shared adder: subtraction adds the inverted operand with inverted borrow
  logic [DATA_W-1:0] bOp;
  logic              carryEff;
  logic [NIB_W:0]    nibSum;
  logic [DATA_W-1:0] lowSevenSum;
  logic [DATA_W:0]   fullSum;
  logic              addCy;

  assign bOp         = strobes.subMode ? ~operandIn : operandIn;
  assign carryEff    = (strobes.useCarry & cyIn) ^ strobes.subMode;
  assign nibSum      = {1'b0, accIn[NIB_W-1:0]} + {1'b0, bOp[NIB_W-1:0]}
                     + {{NIB_W{1'b0}}, carryEff};
  assign lowSevenSum = {1'b0, accIn[DATA_W-2:0]} + {1'b0, bOp[DATA_W-2:0]}
                     + {{(DATA_W-1){1'b0}}, carryEff};
  assign fullSum     = {1'b0, accIn} + {1'b0, bOp} + {{DATA_W{1'b0}}, carryEff};
  assign addCy       = fullSum[DATA_W] ^ strobes.subMode;

  // Decimal adjust, two conditional corrections
  logic            lowFix;
  logic            highFix;
  logic [DATA_W:0] adjOne;
  logic [DATA_W:0] adjTwo;
  logic            daCy;

  assign lowFix  = (accIn[NIB_W-1:0] > NIB_W'(9)) || acIn;
  assign adjOne  = {1'b0, accIn} + (lowFix ? LOW_FIX : '0);
  assign highFix = (adjOne[DATA_W-1:NIB_W] > NIB_W'(9)) || cyIn || adjOne[DATA_W];
  assign adjTwo  = {1'b0, adjOne[DATA_W-1:0]} + (highFix ? HIGH_FIX : '0);
  assign daCy    = cyIn | adjOne[DATA_W] | adjTwo[DATA_W];

  always_comb begin
    unique case (strobes.resSel)
      RES_INC:  result = operandIn + DATA_W'(1);
      RES_DEC:  result = operandIn - DATA_W'(1);
      RES_DADJ: result = adjTwo[DATA_W-1:0];
      default:  result = fullSum[DATA_W-1:0];
    endcase
  end

  assign cyOut = (strobes.resSel == RES_DADJ) ? daCy : addCy;
  assign acOut = nibSum[NIB_W] ^ strobes.subMode;
  assign ovOut = lowSevenSum[DATA_W-1] ^ fullSum[DATA_W];

  // Two-phase pointer increment
  logic [HALF_PTR-1:0] loReg;
  logic [HALF_PTR-1:0] hiReg;
  logic                loCarry;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loReg   <= '0;
      hiReg   <= '0;
      loCarry <= 1'b0;
    end else if (strobes.ptrCapture) begin
      {loCarry, loReg} <= {1'b0, ptrIn[HALF_PTR-1:0]} + (HALF_PTR+1)'(1);
      hiReg            <= ptrIn[PTR_W-1:HALF_PTR];
    end
  end

  assign ptrOut = {hiReg + {{(HALF_PTR-1){1'b0}}, loCarry}, loReg};
endmodule

// File: rtl/accAlu.sv
module accAlu
  import accAluPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        opValid,
  input  logic [2:0]  opSel,
  input  logic [7:0]  accIn,
  input  logic [7:0]  operandIn,
  input  logic        cyIn,
  input  logic        acIn,
  input  logic [15:0] ptrIn,
  output logic [7:0]  result,
  output logic        cyOut,
  output logic        acOut,
  output logic        ovOut,
  output logic        cyWe,
  output logic        acWe,
  output logic        ovWe,
  output logic [15:0] ptrOut,
  output logic        ptrWe,
  output logic        busy
);
  strobeT strobes;

  accAluCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opSel(opSel),
    .strobes(strobes), .busy(busy)
  );

  accAluData u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .accIn(accIn), .operandIn(operandIn), .cyIn(cyIn), .acIn(acIn),
    .ptrIn(ptrIn), .result(result), .cyOut(cyOut), .acOut(acOut),
    .ovOut(ovOut), .ptrOut(ptrOut)
  );

  assign cyWe  = strobes.cyWe;
  assign acWe  = strobes.acWe;
  assign ovWe  = strobes.ovWe;
  assign ptrWe = strobes.ptrDrive;
endmodule

// File: rtl/accAluChecker.sv
module accAluChecker
  import accAluPkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        opValid,
  input logic [2:0]  opSel,
  input logic [7:0]  accIn,
  input logic [7:0]  operandIn,
  input logic        cyIn,
  input logic        acIn,
  input logic [15:0] ptrIn,
  input logic [7:0]  result,
  input logic        cyOut,
  input logic        acOut,
  input logic        ovOut,
  input logic        cyWe,
  input logic        acWe,
  input logic        ovWe,
  input logic [15:0] ptrOut,
  input logic        ptrWe,
  input logic        busy
);
  logic ptrIssue;
  assign ptrIssue = opValid && (opSel == OP_PTRINC) && !busy;

  AST_ARITH_ALL_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    opValid && (opSel == OP_ADD || opSel == OP_ADDC || opSel == OP_SUBB)
      |-> (cyWe && acWe && ovWe)); // R1

  AST_ADD_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rstN)
    opValid && opSel == OP_ADD && operandIn == 8'h00
      |-> (result == accIn && !cyOut && !acOut && !ovOut)); // R2

  AST_INCDEC_NO_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    opValid && (opSel == OP_INC || opSel == OP_DEC)
      |-> !(cyWe || acWe || ovWe)); // R5

  AST_INC_WRAPS: assert property (@(posedge clk) disable iff (!rstN)
    opValid && opSel == OP_INC |-> result == operandIn + 8'd1); // R5

  AST_DA_ZERO_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    opValid && opSel == OP_DADJ && accIn == 8'h00 && !acIn && !cyIn
      |-> (result == 8'h00 && !cyOut)); // R6

  AST_DA_CY_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    opValid && opSel == OP_DADJ |-> (cyWe && !acWe && !ovWe)); // R7

  AST_DA_KEEPS_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    opValid && opSel == OP_DADJ && cyIn |-> cyOut); // R7

  AST_PTR_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    ptrIssue |=> (ptrWe && busy && ptrOut == $past(ptrIn) + 16'd1)); // R8

  AST_PTR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    ptrWe |=> !ptrWe); // R8

  AST_IDLE_NO_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (!opValid || opSel == OP_NONE || opSel == OP_PTRINC)
      |-> !(cyWe || acWe || ovWe)); // R9
endmodule

bind accAlu accAluChecker u_chk (.*);

// File: tb/sim_accAlu.sv
`timescale 1ns/1ps
module sim_accAlu;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [2:0]  opSel = 3'd7;
  logic [7:0]  accIn = '0;
  logic [7:0]  operandIn = '0;
  logic        cyIn = 1'b0;
  logic        acIn = 1'b0;
  logic [15:0] ptrIn = '0;
  logic [7:0]  result;
  logic        cyOut, acOut, ovOut, cyWe, acWe, ovWe, ptrWe, busy;
  logic [15:0] ptrOut;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  accAlu u0 (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opSel(opSel),
    .accIn(accIn), .operandIn(operandIn), .cyIn(cyIn), .acIn(acIn),
    .ptrIn(ptrIn), .result(result), .cyOut(cyOut), .acOut(acOut),
    .ovOut(ovOut), .cyWe(cyWe), .acWe(acWe), .ovWe(ovWe),
    .ptrOut(ptrOut), .ptrWe(ptrWe), .busy(busy)
  );

  // {op, acc, operand, cyIn, acIn, result, cy, ac, ov, we[cy,ac,ov]}
  localparam int NV = 18;
  localparam logic [34:0] VEC [NV] = '{
    {3'd0, 8'h7F, 8'h01, 1'b0, 1'b0, 8'h80, 1'b0, 1'b1, 1'b1, 3'b111},
    {3'd0, 8'hFF, 8'h01, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 3'b111},
    {3'd0, 8'h10, 8'h20, 1'b1, 1'b0, 8'h30, 1'b0, 1'b0, 1'b0, 3'b111},
    {3'd0, 8'h80, 8'h80, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 3'b111},
    {3'd1, 8'h0F, 8'h00, 1'b1, 1'b0, 8'h10, 1'b0, 1'b1, 1'b0, 3'b111},
    {3'd1, 8'hFF, 8'hFF, 1'b1, 1'b0, 8'hFF, 1'b1, 1'b1, 1'b0, 3'b111},
    {3'd1, 8'h3F, 8'h40, 1'b1, 1'b0, 8'h80, 1'b0, 1'b1, 1'b1, 3'b111},
    {3'd2, 8'h00, 8'h01, 1'b0, 1'b0, 8'hFF, 1'b1, 1'b1, 1'b0, 3'b111},
    {3'd2, 8'h80, 8'h01, 1'b0, 1'b0, 8'h7F, 1'b0, 1'b1, 1'b1, 3'b111},
    {3'd2, 8'h50, 8'h20, 1'b1, 1'b0, 8'h2F, 1'b0, 1'b1, 1'b0, 3'b111},
    {3'd2, 8'h10, 8'h10, 1'b1, 1'b0, 8'hFF, 1'b1, 1'b1, 1'b0, 3'b111},
    {3'd2, 8'h37, 8'h12, 1'b0, 1'b0, 8'h25, 1'b0, 1'b0, 1'b0, 3'b111},
    {3'd5, 8'h0C, 8'h00, 1'b0, 1'b0, 8'h12, 1'b0, 1'b0, 1'b0, 3'b100},
    {3'd5, 8'h9A, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 3'b100},
    {3'd5, 8'h15, 8'h00, 1'b0, 1'b1, 8'h1B, 1'b0, 1'b0, 1'b0, 3'b100},
    {3'd5, 8'h15, 8'h00, 1'b1, 1'b0, 8'h75, 1'b1, 1'b0, 1'b0, 3'b100},
    {3'd5, 8'hA0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 3'b100},
    {3'd5, 8'h42, 8'h00, 1'b0, 1'b0, 8'h42, 1'b0, 1'b0, 1'b0, 3'b100}
  };

  function automatic string tagOf(input logic [2:0] op);
    case (op)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd5: return "R6/R7";
      default: return "R1";
    endcase
  endfunction

  task automatic expectVal(input string tag, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic applyOp(input logic [2:0] op, input logic [7:0] a,
                         input logic [7:0] b, input logic ci, input logic ai);
    @(negedge clk);
    opValid = 1'b1; opSel = op; accIn = a; operandIn = b; cyIn = ci; acIn = ai;
    #1;
  endtask

  initial begin : watchdog
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int pulses;
    // R10: reset state
    #1;
    expectVal("R10", "busy", 32'(busy), 32'd0);
    expectVal("R10", "ptrWe", 32'(ptrWe), 32'd0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [34:0] v;
      v = VEC[i];
      applyOp(v[34:32], v[31:24], v[23:16], v[15], v[14]);
      expectVal(tagOf(v[34:32]), "result", 32'(result), 32'(v[13:6]));
      expectVal(tagOf(v[34:32]), "cy", 32'(cyOut), 32'(v[5]));
      if (v[34:32] != 3'd5) begin
        expectVal(tagOf(v[34:32]), "ac", 32'(acOut), 32'(v[4]));
        expectVal(tagOf(v[34:32]), "ov", 32'(ovOut), 32'(v[3]));
      end
      expectVal(v[34:32] == 3'd5 ? "R7" : "R1", "flag we",
                32'({cyWe, acWe, ovWe}), 32'(v[2:0]));
    end

    // R5: increment / decrement wrap and write no flags
    applyOp(3'd3, 8'h00, 8'hFF, 1'b1, 1'b1);
    expectVal("R5", "inc wrap", 32'(result), 32'h00);
    expectVal("R5", "inc we", 32'({cyWe, acWe, ovWe}), 32'd0);
    applyOp(3'd4, 8'hFF, 8'h00, 1'b1, 1'b1);
    expectVal("R5", "dec wrap", 32'(result), 32'hFF);
    expectVal("R5", "dec we", 32'({cyWe, acWe, ovWe}), 32'd0);
    applyOp(3'd3, 8'h00, 8'h7F, 1'b0, 1'b0);
    expectVal("R5", "inc mid", 32'(result), 32'h80);

    // R9: invalid or no-op writes no flag
    applyOp(3'd0, 8'hFF, 8'hFF, 1'b1, 1'b1);
    opValid = 1'b0; #1;
    expectVal("R9", "idle we", 32'({cyWe, acWe, ovWe}), 32'd0);
    applyOp(3'd7, 8'hFF, 8'hFF, 1'b1, 1'b1);
    expectVal("R9", "nop we", 32'({cyWe, acWe, ovWe}), 32'd0);

    // R8: pointer increment, wrap and carry between bytes
    applyOp(3'd6, 8'h00, 8'h00, 1'b0, 1'b0);
    ptrIn = 16'hFFFF;
    expectVal("R8", "ptr issue we", 32'({cyWe, acWe, ovWe, ptrWe}), 32'd0);
    @(negedge clk);
    opValid = 1'b0; #1;
    expectVal("R8", "ptrWe", 32'(ptrWe), 32'd1);
    expectVal("R8", "busy", 32'(busy), 32'd1);
    expectVal("R8", "ptr wrap", 32'(ptrOut), 32'h0000);
    @(negedge clk); #1;
    expectVal("R8", "ptrWe drop", 32'(ptrWe), 32'd0);

    applyOp(3'd6, 8'h00, 8'h00, 1'b0, 1'b0);
    ptrIn = 16'h12FF;
    @(negedge clk);
    opValid = 1'b0; #1;
    expectVal("R8", "ptr carry", 32'(ptrOut), 32'h1300);

    // R8: issue held during busy cycle is ignored
    @(negedge clk);
    applyOp(3'd6, 8'h00, 8'h00, 1'b0, 1'b0);
    ptrIn = 16'h0041;
    pulses = 0;
    @(negedge clk);
    ptrIn = 16'h7777; #1;
    if (ptrWe) pulses++;
    expectVal("R8", "first value", 32'(ptrOut), 32'h0042);
    @(negedge clk);
    opValid = 1'b0; #1;
    if (ptrWe) pulses++;
    @(negedge clk); #1;
    if (ptrWe) pulses++;
    expectVal("R8", "pulse count", 32'(pulses), 32'd1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule